// File: doc/BRIEF.md
# Error-Correcting Register File with Upset Counters

This block holds eight 32-bit words. Each word is stored with seven check bits: six Hamming parity bits and one overall parity bit, which gives a 39-bit entry. A host picks one of the entries with a 3-bit index. It stores a word by pulsing a write strobe, or fetches one by pulsing a read strobe. On every fetch the block decodes the stored entry and repairs a single flipped bit. It then returns the data together with a 2-bit status that says whether the word was clean, repaired or beyond repair.

Two saturating counters record how often reads met a repairable upset and how often they met an unrepairable one. The repairable-upset count can be read through a small bus port with a valid/acknowledge handshake. That port is read-only: it acknowledges writes and drops them. The unrepairable count is driven on a dedicated output. An active-low asynchronous reset clears every entry and both counters.

Top module: `ecc_rf_top`

## Requirements
- R1: While reset is low and after it is released, every entry reads back as zero with status 2'b00. Both counters are zero and the bus acknowledge is low.
- R2: A write strobe stores the write data into the entry named by the select input. When the read strobe is sampled alone at a clock edge, that entry's data and status appear on the outputs right after that edge. The outputs then hold until the next read.
- R3: When both strobes are high in the same cycle, only the write takes place. The read outputs keep their previous values.
- R4: A flip of any one of the 39 stored bits is repaired on read. The original data is returned with status 2'b01.
- R5: Any two flipped bits in one entry are reported with status 2'b10. The data output is then unspecified.
- R6: The repairable counter rises by one for each read with status 2'b01. The unrepairable counter rises by one for each read with status 2'b10. Clean reads change neither counter.
- R7: Both counters stop at their all-ones value and stay there instead of wrapping.
- R8: When bus valid is sampled high while the acknowledge is low, the acknowledge is high for exactly the next cycle. Bus read data then carries the repairable count as it stood at that sampling edge, zero-extended. If valid is held high, the acknowledge alternates high and low.
- R9: A bus access with any byte strobe set is acknowledged like a read and changes no counter.
- R10: The status code 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_sel_i | input | 3 | Entry index for host write and read |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| wr_data_i | input | 32 | Host write data |
| rd_data_o | output | 32 | Repaired read data |
| rd_status_o | output | 2 | 00 clean, 01 repaired, 10 unrepairable |
| err_dbl_cnt_o | output | 32 | Unrepairable-error count, zero-extended |
| bus_valid_i | input | 1 | Bus request valid |
| bus_strb_i | input | 4 | Bus byte strobes (writes are dropped) |
| bus_wdata_i | input | 32 | Bus write data (unused) |
| bus_ack_o | output | 1 | Bus acknowledge, one-cycle pulse |
| bus_rdata_o | output | 32 | Repairable-error count, zero-extended |

## Verification
A host read that finds a repairable upset can land in the same cycle as a bus access of the counter it increments. The bench provokes this by raising the read strobe and bus valid at the same edge on an entry with one injected flip. The bus must return the count from before that edge, and a later bus read must show it one higher. A write and a read in the same cycle are also provoked, by directed and random stimulus, and judged by the read outputs staying unchanged.

// File: rtl/ecc_rf_pkg.sv
package ecc_rf_pkg;
  localparam int DATA_W = 32;
  localparam int PAR_W  = 6;
  localparam int CODE_W = DATA_W + PAR_W + 1;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_FATAL = 2'b10
  } ecc_status_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    ecc_status_e       status;
  } ecc_result_t;

  function automatic logic is_pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Bit 0 is overall parity; bit p (p >= 1) is Hamming position p.
  function automatic logic [CODE_W-1:0] ecc_encode(logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!is_pow2(p)) begin
        c[p] = d[j];
        j++;
      end
    end
    for (int k = 0; k < PAR_W; k++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p < CODE_W; p++) begin
        if ((p & (1 << k)) != 0) x ^= c[p];
      end
      c[1 << k] = x;
    end
    c[0] = ^c[CODE_W-1:1];
    return c;
  endfunction

  function automatic ecc_result_t ecc_decode(logic [CODE_W-1:0] c);
    logic [PAR_W-1:0]  syn;
    logic              ovr;
    logic [CODE_W-1:0] fix;
    ecc_result_t       r;
    int j;
    syn = '0;
    for (int k = 0; k < PAR_W; k++) begin
      for (int p = 1; p < CODE_W; p++) begin
        if ((p & (1 << k)) != 0) syn[k] ^= c[p];
      end
    end
    ovr      = ^c;
    fix      = c;
    r.status = ST_CLEAN;
    if (ovr) begin
      if (int'(syn) < CODE_W) begin
        fix[syn] = ~fix[syn];
        r.status = ST_FIXED;
      end else begin
        r.status = ST_FATAL;
      end
    end else if (syn != '0) begin
      r.status = ST_FATAL;
    end
    r.data = '0;
    j = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!is_pow2(p)) begin
        r.data[j] = fix[p];
        j++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_rf_store.sv
module ecc_rf_store #(
  parameter int NREG   = 8,
  parameter int CODE_W = 39,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [CODE_W-1:0] wcode_i,
  output logic [CODE_W-1:0] rcode_o
);
  logic [CODE_W-1:0] mem_q [NREG];
  logic [CODE_W-1:0] mem_d [NREG];
  logic [NREG-1:0]   mem_en;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      mem_en[i] = we_i && (int'(sel_i) == i);
      mem_d[i]  = wcode_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (mem_en[i]) mem_q[i] <= mem_d[i];
      end
    end
  end

  assign rcode_o = mem_q[sel_i];
endmodule

// File: rtl/ecc_rf_satcnt.sv
module ecc_rf_satcnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = inc_i && !(&cnt_q);
    cnt_d  = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ecc_rf_busport.sv
module ecc_rf_busport #(
  parameter int BUS_W = 32,
  localparam int STRB_W = BUS_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [STRB_W-1:0] strb_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [BUS_W-1:0]  cnt_i,
  output logic              ack_o,
  output logic [BUS_W-1:0]  rdata_o
);
  logic             ack_q;
  logic             ack_d;
  logic [BUS_W-1:0] rdata_q;
  logic             take;
  logic             unused_wr;

  // The counter is read-only: strobes and write data are dropped.
  assign unused_wr = ^{strb_i, wdata_i};

  always_comb begin
    take  = valid_i && !ack_q;
    ack_d = take;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= ack_d;
      if (take) rdata_q <= cnt_i;
    end
  end

  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/ecc_rf_top.sv
module ecc_rf_top
  import ecc_rf_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int CNT_W = 32,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [1:0]        rd_status_o,
  output logic [DATA_W-1:0] err_dbl_cnt_o,
  input  logic              bus_valid_i,
  input  logic [3:0]        bus_strb_i,
  input  logic [31:0]       bus_wdata_i,
  output logic              bus_ack_o,
  output logic [31:0]       bus_rdata_o
);
  logic [CODE_W-1:0] wcode;
  logic [CODE_W-1:0] rcode;
  ecc_result_t       dec;
  logic              rd_fire;
  logic [DATA_W-1:0] rd_data_q;
  ecc_status_e       rd_status_q;
  logic [CNT_W-1:0]  sgl_cnt;
  logic [CNT_W-1:0]  dbl_cnt;
  logic              sgl_inc;
  logic              dbl_inc;
  logic [31:0]       sgl_ext;

  assign wcode = ecc_encode(wr_data_i);

  ecc_rf_store #(.NREG(NREG), .CODE_W(CODE_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .sel_i   (reg_sel_i),
    .wcode_i (wcode),
    .rcode_o (rcode)
  );

  always_comb begin
    dec     = ecc_decode(rcode);
    rd_fire = rd_en_i && !wr_en_i;
    sgl_inc = rd_fire && (dec.status == ST_FIXED);
    dbl_inc = rd_fire && (dec.status == ST_FATAL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q   <= '0;
      rd_status_q <= ST_CLEAN;
    end else if (rd_fire) begin
      rd_data_q   <= dec.data;
      rd_status_q <= dec.status;
    end
  end

  ecc_rf_satcnt #(.W(CNT_W)) u_sgl_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (sgl_inc), .cnt_o (sgl_cnt)
  );

  ecc_rf_satcnt #(.W(CNT_W)) u_dbl_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (dbl_inc), .cnt_o (dbl_cnt)
  );

  always_comb begin
    sgl_ext                  = '0;
    sgl_ext[CNT_W-1:0]       = sgl_cnt;
    err_dbl_cnt_o            = '0;
    err_dbl_cnt_o[CNT_W-1:0] = dbl_cnt;
  end

  ecc_rf_busport #(.BUS_W(32)) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (bus_valid_i),
    .strb_i  (bus_strb_i),
    .wdata_i (bus_wdata_i),
    .cnt_i   (sgl_ext),
    .ack_o   (bus_ack_o),
    .rdata_o (bus_rdata_o)
  );

  assign rd_data_o   = rd_data_q;
  assign rd_status_o = rd_status_q;
endmodule

// File: rtl/ecc_rf_checker.sv
module ecc_rf_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [31:0]      rd_data_o,
  input logic [1:0]       rd_status_o,
  input logic             bus_valid_i,
  input logic             bus_ack_o,
  input logic [CNT_W-1:0] sgl_cnt_i,
  input logic [CNT_W-1:0] dbl_cnt_i
);
  assert_status_legal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_status_o != 2'b11);

  assert_wr_priority_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_en_i) |=> ($stable(rd_data_o) && $stable(rd_status_o)));

  assert_sgl_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sgl_cnt_i != $past(sgl_cnt_i)) |->
      ((sgl_cnt_i - $past(sgl_cnt_i)) == CNT_W'(1) && $past(rd_en_i && !wr_en_i)));

  assert_dbl_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbl_cnt_i != $past(dbl_cnt_i)) |->
      ((dbl_cnt_i - $past(dbl_cnt_i)) == CNT_W'(1) && $past(rd_en_i && !wr_en_i)));

  assert_sat_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&$past(sgl_cnt_i)) |-> (&sgl_cnt_i));

  assert_ack_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o |-> ($past(bus_valid_i) && !$past(bus_ack_o)));
endmodule

bind ecc_rf_top ecc_rf_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .rd_data_o   (rd_data_o),
  .rd_status_o (rd_status_o),
  .bus_valid_i (bus_valid_i),
  .bus_ack_o   (bus_ack_o),
  .sgl_cnt_i   (sgl_cnt),
  .dbl_cnt_i   (dbl_cnt)
);

// File: tb/ecc_rf_top_bench.sv
`timescale 1ns/1ps
module ecc_rf_top_bench;
  localparam int CNT_W = 6;
  localparam int MAXC  = (1 << CNT_W) - 1;
  localparam int NBITS = 39;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  sel;
  logic        wr, rd;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [1:0]  status;
  logic [31:0] dbl_cnt;
  logic        bvalid;
  logic [3:0]  bstrb;
  logic [31:0] bwdata;
  logic        back;
  logic [31:0] brdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] exp_mem [8];
  int          flips [8];
  int          sgl_m = 0;
  int          dbl_m = 0;

  always #2.5 clk = ~clk;

  ecc_rf_top #(.NREG(8), .CNT_W(CNT_W)) u_ecc_rf_top (
    .clk_i (clk), .rst_ni (rst_n), .reg_sel_i (sel), .wr_en_i (wr), .rd_en_i (rd),
    .wr_data_i (wdata), .rd_data_o (rdata), .rd_status_o (status),
    .err_dbl_cnt_o (dbl_cnt), .bus_valid_i (bvalid), .bus_strb_i (bstrb),
    .bus_wdata_i (bwdata), .bus_ack_o (back), .bus_rdata_o (brdata)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int sat_inc(int v);
    return (v >= MAXC) ? MAXC : v + 1;
  endfunction

  function automatic logic [1:0] exp_status(int n);
    return (n == 0) ? 2'b00 : (n == 1) ? 2'b01 : 2'b10;
  endfunction

  // Error injection: flip one stored bit of an entry between clock edges.
  task automatic inject(int idx, int pos);
    u_ecc_rf_top.u_store.mem_q[idx][pos] = ~u_ecc_rf_top.u_store.mem_q[idx][pos];
    flips[idx]++;
  endtask

  task automatic do_write(int idx, logic [31:0] d);
    sel = 3'(idx); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    exp_mem[idx] = d;
    flips[idx] = 0;
  endtask

  task automatic do_read(int idx, string tag);
    logic [1:0] es;
    es = exp_status(flips[idx]);
    sel = 3'(idx); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check(status == es, tag, 32'(status), 32'(es));
    check(status != 2'b11, "R10 status legal", 32'(status), 32'h0);
    if (flips[idx] < 2) check(rdata == exp_mem[idx], tag, rdata, exp_mem[idx]);
    if (flips[idx] == 1) sgl_m = sat_inc(sgl_m);
    if (flips[idx] == 2) dbl_m = sat_inc(dbl_m);
    check(dbl_cnt == 32'(dbl_m), "R6 dbl count", dbl_cnt, 32'(dbl_m));
  endtask

  task automatic bus_access(logic [3:0] strb, string tag);
    bvalid = 1'b1; bstrb = strb; bwdata = $urandom;
    @(negedge clk);
    bvalid = 1'b0; bstrb = 4'h0;
    check(back == 1'b1, {tag, " ack"}, 32'(back), 32'h1);
    check(brdata == 32'(sgl_m), {tag, " count"}, brdata, 32'(sgl_m));
    @(negedge clk);
    check(back == 1'b0, {tag, " ack drop"}, 32'(back), 32'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] before_d;
    logic [1:0]  before_s;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; sel = '0; wr = 0; rd = 0; wdata = '0;
    bvalid = 0; bstrb = '0; bwdata = '0;
    for (int i = 0; i < 8; i++) begin exp_mem[i] = '0; flips[i] = 0; end
    repeat (3) @(negedge clk);
    check(rdata == 32'h0 && status == 2'b00, "R1 outputs in reset", rdata, 32'h0);
    check(back == 1'b0, "R1 ack in reset", 32'(back), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dbl_cnt == 32'h0, "R1 dbl count", dbl_cnt, 32'h0);
    bus_access(4'h0, "R1 bus count zero");
    for (int i = 0; i < 8; i++) do_read(i, "R1 entry zero");

    // R2: directed writes and reads
    for (int i = 0; i < 8; i++) do_write(i, 32'hA5A5_0000 | 32'(i * 32'h1111));
    for (int i = 7; i >= 0; i--) do_read(i, "R2 read back");
    do_write(3, 32'hFFFF_FFFF);
    do_read(3, "R2 all ones");
    @(negedge clk);
    check(rdata == 32'hFFFF_FFFF, "R2 hold", rdata, 32'hFFFF_FFFF);

    // R3: both strobes
    do_write(2, 32'h1234_5678);
    do_read(4, "R3 setup");
    before_d = rdata; before_s = status;
    sel = 3'd2; wdata = 32'hCAFE_F00D; wr = 1; rd = 1;
    @(negedge clk);
    wr = 0; rd = 0;
    exp_mem[2] = 32'hCAFE_F00D; flips[2] = 0;
    check(rdata == before_d && status == before_s, "R3 read suppressed", rdata, before_d);
    do_read(2, "R3 write took effect");

    // R4: every single position
    for (int p = 0; p < NBITS; p++) begin
      do_write(1, $urandom);
      inject(1, p);
      do_read(1, "R4 single flip");
    end
    bus_access(4'h0, "R6 sgl count");

    // R5: double flips
    for (int n = 0; n < 12; n++) begin
      int p1, p2;
      p1 = int'($urandom % NBITS);
      p2 = (p1 + 1 + int'($urandom % (NBITS - 1))) % NBITS;
      do_write(6, $urandom);
      inject(6, p1); inject(6, p2);
      do_read(6, "R5 double flip");
    end
    do_write(6, 32'h0F0F_0F0F);
    do_read(6, "R6 clean read");
    bus_access(4'h0, "R6 clean read no change");

    // R9: bus write dropped
    bus_access(4'hF, "R9 bus write");
    bus_access(4'h1, "R9 bus write partial");

    // R8: held valid alternates
    bvalid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(back == ((k % 2) == 0), "R8 held valid", 32'(back), 32'((k % 2) == 0));
    end
    bvalid = 1'b0;
    @(negedge clk);

    // R8: bus read and counting read in the same cycle
    do_write(5, 32'h0BAD_BEEF);
    inject(5, 17);
    sel = 3'd5; rd = 1; bvalid = 1;
    @(negedge clk);
    rd = 0; bvalid = 0;
    check(status == 2'b01, "R8 concurrent status", 32'(status), 32'h1);
    check(brdata == 32'(sgl_m), "R8 concurrent old count", brdata, 32'(sgl_m));
    sgl_m = sat_inc(sgl_m);
    @(negedge clk);
    bus_access(4'h0, "R8 count after concurrent");

    // random mix
    for (int n = 0; n < 300; n++) begin
      int idx, op;
      idx = int'($urandom % 8);
      op  = int'($urandom % 4);
      if (op == 0) do_write(idx, $urandom);
      else if (op == 3) begin
        before_d = rdata; before_s = status;
        sel = 3'(idx); wdata = $urandom; wr = 1; rd = 1;
        @(negedge clk);
        wr = 0; rd = 0;
        exp_mem[idx] = wdata; flips[idx] = 0;
        check(rdata == before_d && status == before_s, "R3 random both", rdata, before_d);
      end else begin
        if (flips[idx] == 0 && ($urandom % 3) == 0) begin
          int p1;
          p1 = int'($urandom % NBITS);
          inject(idx, p1);
          if ($urandom % 2 == 1) inject(idx, (p1 + 1 + int'($urandom % (NBITS - 1))) % NBITS);
        end
        do_read(idx, "R4 R5 random read");
      end
    end
    bus_access(4'h0, "R6 random count");

    // R7: saturation of both counters
    do_write(0, 32'h7777_1111);
    inject(0, 9);
    for (int n = 0; n < MAXC + 8; n++) do_read(0, "R7 sgl saturate");
    bus_access(4'h0, "R7 sgl saturated");
    check(sgl_m == MAXC, "R7 model saturated", 32'(sgl_m), 32'(MAXC));
    inject(0, 30);
    for (int n = 0; n < MAXC + 8; n++) do_read(0, "R7 dbl saturate");
    check(dbl_cnt == 32'(MAXC), "R7 dbl saturated", dbl_cnt, 32'(MAXC));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule